// File: doc/BRIEF.md
# Asynchronous Memory Bus Master

This block sits between a processor-side request port and an external memory that signals completion with a ready line, not after a fixed delay. A requester presents a single transfer (read or write, address, write data, and byte or word size). The block turns it into a bus transaction: it drives a one-way address bus, a data bus split into output value, output enable and input value, and read, write and size strobes. It then holds the transaction open until the memory raises ready.

Writes get a programmable number of setup cycles. During these cycles the address, data and size are already on the bus and steady, and only then is the write strobe raised. Reads raise the read strobe together with the address and size, and they latch the returned data in the cycle in which ready is sampled. Byte reads are narrowed to the addressed byte lane and zero-extended. If the memory never answers, a cycle-count timeout ends the transaction with an error flag. Every accepted request produces exactly one completion pulse.

Top module: `amb_master`

## Requirements
- R1: After reset the block is idle: `req_ready_o` is 1, and `mem_rd_o`, `mem_wr_o`, `mem_data_oe_o` and `rsp_done_o` are 0.
- R2: A read raises `mem_rd_o` in the cycle after the request is taken. `mem_addr_o` and `mem_size_o` are valid in that same cycle and steady until the end. The strobe stays high until a clock edge samples `mem_ready_i` high; the data bus is captured at that edge.
- R3: A write holds `mem_wr_o` high until a clock edge samples `mem_ready_i` high. The memory stores the value on `mem_wdata_o`.
- R4: For writes, `mem_data_oe_o`, `mem_addr_o` and `mem_wdata_o` are driven and steady for exactly SETUP_CYC cycles (default 2, minimum 1) before `mem_wr_o` rises.
- R5: `mem_size_o` is 0 for a byte transfer and 1 for a full-word transfer. On a byte write, the low byte of the write data is copied into every byte lane of `mem_wdata_o`.
- R6: A byte read returns the lane chosen by the low address bits in `rsp_rdata_o[7:0]`, with all upper bits 0. Lane 0 is bits 7:0 and lane k is bits 8k+7:8k. A word read returns the whole bus.
- R7: `mem_data_oe_o` is high only during write transactions and is low in the cycle after ready is sampled. `mem_rd_o` and `mem_wr_o` are never high together.
- R8: If a strobe has been high for TIMEOUT_CYC cycles (default 64) without ready, both strobes drop and the transaction completes with `rsp_err_o` = 1.
- R9: A request is taken only while `req_ready_o` is 1. `req_valid_i` while busy starts no transaction and changes no bus output.
- R10: Each taken request yields exactly one single-cycle `rsp_done_o` pulse, one cycle after ready is sampled. On a normal completion `rsp_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 1 | 0 = byte, 1 = word |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Write data (byte writes use bits 7:0) |
| req_ready_o | output | 1 | Idle, request will be taken |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Timeout flag, valid with done |
| rsp_rdata_o | output | DATA_W | Captured, formatted read data |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_wdata_o | output | DATA_W | Data bus output value |
| mem_data_oe_o | output | 1 | Data bus output enable |
| mem_rdata_i | input | DATA_W | Data bus input value |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_size_o | output | 1 | Transfer size strobe |
| mem_ready_i | input | 1 | Memory ready |

## Verification
The bench targets the points where a handshake master usually goes wrong. It measures the number of steady cycles before the write strobe, which catches an off-by-one setup counter. It counts strobe cycles against the memory latency and the timeout limit, so a block that drops the strobe early or waits one cycle too long is exposed. It reads every byte lane of a known word, so a wrong lane select or missing zero-extension returns the wrong value. It raises a request while a transfer is in flight, and checks that no extra completion or stray write appears, and that the output enable never overlaps a read or outlives the ready cycle.

// File: rtl/amb_pkg.sv
package amb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_WSETUP  = 3'd2,
        ST_WSTROBE = 3'd3,
        ST_DONE    = 3'd4
    } amb_state_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } amb_size_e;

    // Sequencer outputs bundled for the top level
    typedef struct packed {
        amb_state_e state;
        logic       accept;
        logic       capture;
        logic       err;
    } amb_seq_t;

    function automatic logic is_strobe_state(amb_state_e s);
        return (s == ST_READ) || (s == ST_WSTROBE);
    endfunction

    function automatic logic is_drive_state(amb_state_e s);
        return (s == ST_WSETUP) || (s == ST_WSTROBE);
    endfunction

endpackage

// File: rtl/amb_req_latch.sv
module amb_req_latch
    import amb_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  amb_size_e         size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output amb_size_e         size_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);
    localparam int unsigned LANES = DATA_W / 8;

    logic [DATA_W-1:0] wdata_fmt;

    // Byte writes copy the low byte onto every lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wdata_fmt[8*g +: 8] = (size_i == SZ_BYTE) ? wdata_i[7:0] : wdata_i[8*g +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            size_o  <= SZ_WORD;
            addr_o  <= '0;
            wdata_o <= '0;
        end else if (load_i) begin
            size_o  <= size_i;
            addr_o  <= addr_i;
            wdata_o <= wdata_fmt;
        end
    end

endmodule

// File: rtl/amb_seq_fsm.sv
module amb_seq_fsm
    import amb_pkg::*;
#(
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned TIMEOUT_CYC = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid_i,
    input  logic     req_write_i,
    input  logic     mem_ready_i,
    output amb_seq_t seq_o
);
    localparam int unsigned CNT_MAX = (SETUP_CYC > TIMEOUT_CYC) ? SETUP_CYC : TIMEOUT_CYC;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(TIMEOUT_CYC - 1);

    amb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             err_q, err_d;
    logic             accept, capture;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        err_d   = err_q;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    accept  = 1'b1;
                    err_d   = 1'b0;
                    cnt_d   = '0;
                    state_d = req_write_i ? ST_WSETUP : ST_READ;
                end
            end
            ST_WSETUP: begin
                if (cnt_q == SETUP_LAST) begin
                    cnt_d   = '0;
                    state_d = ST_WSTROBE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_READ, ST_WSTROBE: begin
                if (mem_ready_i) begin
                    capture = (state_q == ST_READ);
                    state_d = ST_DONE;
                end else if (cnt_q == TMO_LAST) begin
                    err_d   = 1'b1;
                    state_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin
                cnt_d   = '0;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            err_q   <= err_d;
        end
    end

    assign seq_o = '{state: state_q, accept: accept, capture: capture, err: err_q};

    // R8
    tmo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        is_strobe_state(state_q) |-> (cnt_q <= TMO_LAST));

    // R4
    setup_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WSETUP) |-> (cnt_q <= SETUP_LAST));

endmodule

// File: rtl/amb_rdata_fmt.sv
module amb_rdata_fmt
    import amb_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANE_W = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] bus_i,
    input  logic [LANE_W-1:0] lane_i,
    input  amb_size_e         size_i,
    output logic [DATA_W-1:0] data_o
);
    always_comb begin
        if (size_i == SZ_WORD) begin
            data_o = bus_i;
        end else begin
            data_o = {{(DATA_W-8){1'b0}}, bus_i[8*lane_i +: 8]};
        end
    end

endmodule

// File: rtl/amb_master.sv
module amb_master
    import amb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_size_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              rsp_done_o,
    output logic              rsp_err_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_data_oe_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              mem_size_o,
    input  logic              mem_ready_i
);
    localparam int unsigned LANE_W = $clog2(DATA_W / 8);

    amb_seq_t          seq;
    amb_size_e         size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_fmt;
    logic [DATA_W-1:0] rdata_q;

    amb_seq_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid_i(req_valid_i),
        .req_write_i(req_write_i),
        .mem_ready_i(mem_ready_i),
        .seq_o      (seq)
    );

    amb_req_latch #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .load_i (seq.accept),
        .size_i (amb_size_e'(req_size_i)),
        .addr_i (req_addr_i),
        .wdata_i(req_wdata_i),
        .size_o (size_q),
        .addr_o (addr_q),
        .wdata_o(wdata_q)
    );

    amb_rdata_fmt #(
        .DATA_W(DATA_W)
    ) u_fmt (
        .bus_i (mem_rdata_i),
        .lane_i(addr_q[LANE_W-1:0]),
        .size_i(size_q),
        .data_o(rdata_fmt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (seq.capture) begin
            rdata_q <= rdata_fmt;
        end
    end

    assign req_ready_o   = (seq.state == ST_IDLE);
    assign rsp_done_o    = (seq.state == ST_DONE);
    assign rsp_err_o     = rsp_done_o && seq.err;
    assign rsp_rdata_o   = rdata_q;
    assign mem_addr_o    = addr_q;
    assign mem_wdata_o   = wdata_q;
    assign mem_size_o    = size_q;
    assign mem_rd_o      = (seq.state == ST_READ);
    assign mem_wr_o      = (seq.state == ST_WSTROBE);
    assign mem_data_oe_o = is_drive_state(seq.state);

    // R7
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o));

    // R7
    oe_not_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> !mem_data_oe_o);

    // R7
    release_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o || mem_wr_o) && mem_ready_i |=>
            !mem_rd_o && !mem_wr_o && !mem_data_oe_o && rsp_done_o);

    // R4
    setup_before_wr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_wr_o) |-> $past(mem_data_oe_o) && $stable(mem_addr_o) && $stable(mem_wdata_o));

    // R2
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o && $past(mem_rd_o) |-> $stable(mem_addr_o) && $stable(mem_size_o));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready_o |=> $stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_size_o));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done_o |=> !rsp_done_o && req_ready_o);

    // R8
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err_o |-> rsp_done_o);

endmodule

// File: tb/amb_master_tb_top.sv
`timescale 1ns/1ps
module amb_master_tb_top;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int SETUP   = 2;
    localparam int TIMEOUT = 64;
    localparam int NEVER   = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_size  = 1'b1;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready_o, rsp_done_o, rsp_err_o;
    logic [DATA_W-1:0] rsp_rdata_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [DATA_W-1:0] mem_wdata_o;
    logic              mem_data_oe_o, mem_rd_o, mem_wr_o, mem_size_o;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_ready = 1'b0;

    always #5 clk = ~clk;

    amb_master #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP), .TIMEOUT_CYC(TIMEOUT)
    ) dut_i (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_size_i(req_size),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .req_ready_o(req_ready_o), .rsp_done_o(rsp_done_o), .rsp_err_o(rsp_err_o),
        .rsp_rdata_o(rsp_rdata_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_data_oe_o(mem_data_oe_o),
        .mem_rdata_i(mem_rdata), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_size_o(mem_size_o), .mem_ready_i(mem_ready)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [16];
    int  lat = 0;
    int  stb_cnt = 0;
    logic nr;
    logic prev_fin = 1'b0, wr_prev = 1'b0;
    logic [ADDR_W-1:0] addr_prev = '0;
    logic [DATA_W-1:0] wd_prev = '0;
    int  rd_hi_total = 0, wr_hi_total = 0, done_total = 0;
    int  setup_run = 0, setup_meas = 0, setup_bad = 0;
    int  oe_bad = 0, rel_bad = 0, both_bad = 0, size_last = 0;

    assign mem_rdata = mem[mem_addr_o[5:2]];

    always @(negedge clk) begin
        nr = (mem_rd_o || mem_wr_o) && (stb_cnt >= lat);
        stb_cnt   <= (mem_rd_o || mem_wr_o) ? stb_cnt + 1 : 0;
        mem_ready <= nr;
        prev_fin  <= nr;
        if (mem_wr_o && nr) begin
            if (mem_size_o)
                mem[mem_addr_o[5:2]] <= mem_wdata_o;
            else
                mem[mem_addr_o[5:2]][8*mem_addr_o[1:0] +: 8] <= mem_wdata_o[8*mem_addr_o[1:0] +: 8];
        end
        if (mem_rd_o) rd_hi_total <= rd_hi_total + 1;
        if (mem_wr_o) wr_hi_total <= wr_hi_total + 1;
        if (rsp_done_o) done_total <= done_total + 1;
        if (mem_rd_o || mem_wr_o) size_last <= int'(mem_size_o);
        if (mem_data_oe_o && mem_rd_o) oe_bad <= oe_bad + 1;
        if (mem_rd_o && mem_wr_o) both_bad <= both_bad + 1;
        if (prev_fin && mem_data_oe_o) rel_bad <= rel_bad + 1;
        if (mem_data_oe_o && !mem_wr_o) begin
            if (setup_run > 0 && (mem_addr_o != addr_prev || mem_wdata_o != wd_prev))
                setup_bad <= setup_bad + 1;
            setup_run <= setup_run + 1;
        end else if (!mem_data_oe_o) begin
            setup_run <= 0;
        end
        if (mem_wr_o && !wr_prev) setup_meas <= setup_run;
        wr_prev   <= mem_wr_o;
        addr_prev <= mem_addr_o;
        wd_prev   <= mem_wdata_o;
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic wr, input logic [15:0] addr, input logic [31:0] wd,
                           input logic sz, input int l,
                           output logic [31:0] rd, output logic er,
                           output int rd_hi, output int wr_hi, output int dn);
        int rd0, wr0, d0, n;
        rd0 = rd_hi_total; wr0 = wr_hi_total; d0 = done_total; n = 0;
        lat = l;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done_o && n < 400) begin
            @(negedge clk);
            n++;
        end
        rd = rsp_rdata_o;
        er = rsp_err_o;
        @(negedge clk); #1;
        rd_hi = rd_hi_total - rd0;
        wr_hi = wr_hi_total - wr0;
        dn    = done_total - d0;
    endtask

    logic [31:0] rdv;
    logic        erv;
    int          rh, wh, dn;

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "req_ready", 32'(req_ready_o), 1);
        chk("R1", "strobes", {29'd0, mem_rd_o, mem_wr_o, mem_data_oe_o}, 0);
        chk("R1", "done", 32'(rsp_done_o), 0);
    endtask

    task automatic t_word_write();
        run_txn(1'b1, 16'h0010, 32'hCAFE_0123, 1'b1, 2, rdv, erv, rh, wh, dn);
        chk("R3", "stored word", mem[4], 32'hCAFE_0123);
        chk("R3", "wr strobe cycles", wh, 3);
        chk("R4", "setup cycles", setup_meas, SETUP);
        chk("R4", "setup stable", setup_bad, 0);
        chk("R5", "size word", size_last, 1);
        chk("R10", "err clear", 32'(erv), 0);
        chk("R10", "one done", dn, 1);
    endtask

    task automatic t_word_read();
        run_txn(1'b0, 16'h0010, 32'h0, 1'b1, 0, rdv, erv, rh, wh, dn);
        chk("R2", "read word", rdv, 32'hCAFE_0123);
        chk("R2", "rd strobe cycles", rh, 1);
        run_txn(1'b0, 16'h0004, 32'h0, 1'b1, 4, rdv, erv, rh, wh, dn);
        chk("R2", "read word slow", rdv, 32'hA1B2_C3D4);
        chk("R2", "rd strobe cycles slow", rh, 5);
        chk("R7", "oe during read", oe_bad, 0);
    endtask

    task automatic t_byte_read();
        for (int k = 0; k < 4; k++) begin
            logic [31:0] ex;
            ex = {24'd0, 8'(32'hA1B2_C3D4 >> (8*k))};
            run_txn(1'b0, 16'(4 + k), 32'h0, 1'b0, 1, rdv, erv, rh, wh, dn);
            chk("R6", $sformatf("byte lane %0d", k), rdv, ex);
        end
        chk("R5", "size byte", size_last, 0);
    endtask

    task automatic t_byte_write();
        run_txn(1'b1, 16'h000A, 32'hFFFF_FF5E, 1'b0, 1, rdv, erv, rh, wh, dn);
        chk("R5", "byte lane replicate", mem[2], 32'h005E_0000);
        run_txn(1'b0, 16'h000A, 32'h0, 1'b0, 0, rdv, erv, rh, wh, dn);
        chk("R6", "byte readback", rdv, 32'h0000_005E);
    endtask

    task automatic t_timeout();
        run_txn(1'b0, 16'h0000, 32'h0, 1'b1, NEVER, rdv, erv, rh, wh, dn);
        chk("R8", "read timeout err", 32'(erv), 1);
        chk("R8", "read strobe cycles", rh, TIMEOUT);
        run_txn(1'b1, 16'h0030, 32'h1357_9BDF, 1'b1, NEVER, rdv, erv, rh, wh, dn);
        chk("R8", "write timeout err", 32'(erv), 1);
        chk("R8", "write strobe cycles", wh, TIMEOUT);
        chk("R8", "no store on timeout", mem[12], 32'h0);
        chk("R8", "strobes low after", {30'd0, mem_rd_o, mem_wr_o}, 0);
        chk("R10", "one done on timeout", dn, 1);
    endtask

    task automatic t_busy_ignore();
        int d0, w0, n;
        d0 = done_total; w0 = wr_hi_total; n = 0;
        lat = 5;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0004; req_size = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0020; req_wdata = 32'hDEAD_BEEF;
        chk("R9", "busy ready low", 32'(req_ready_o), 0);
        @(negedge clk);
        chk("R9", "addr held", 32'(mem_addr_o), 32'h0004);
        req_valid = 1'b0;
        while (!rsp_done_o && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk("R2", "read during busy", rsp_rdata_o, 32'hA1B2_C3D4);
        repeat (10) @(negedge clk);
        #1;
        chk("R9", "busy write ignored", mem[8], 32'h0);
        chk("R9", "no wr strobe", wr_hi_total - w0, 0);
        chk("R10", "single done", done_total - d0, 1);
        chk("R7", "release after ready", rel_bad, 0);
        chk("R7", "rd wr exclusive", both_bad, 0);
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        mem[1] = 32'hA1B2_C3D4;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word_write();
        t_word_read();
        t_byte_read();
        t_byte_write();
        t_timeout();
        t_busy_ignore();
        finish_sim();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_sim();
    end

endmodule